// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device side of a serial flash interface, limited to the continuous main-array read. A host lowers chip select and shifts in a one-byte opcode, a 24-bit address and a fixed run of don't-care bits. The block then returns array bytes most-significant bit first, one after another, for as long as chip select stays low. The serial pins are oversampled by the system clock. The block samples SDI on a rising SCK and changes SDO after a falling SCK, so hosts that idle the clock low work as well as hosts that idle it high.

Two read opcodes are accepted, and they differ only in the length of the don't-care run. The array can be viewed as 264-byte pages or as binary 256-byte pages, selected by a static input. Reads move across page ends and across the end of the array with no gap. The storage is a small byte array, and a write port loads it during test. The output pin is modelled as a data bit plus an output enable. When the enable is low, the pin is in high impedance.

Top module: `cr_responder`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_sdo_oe` is 0.
- R2: Opcode 8'hE8 is followed by 24 address bits and then 32 don't-care bits. On each falling SCK after that, SDO presents the next data bit, MSB first, with `spi_sdo_oe` = 1. SDO changes only after a falling SCK.
- R3: Opcode 8'h0B is followed by 24 address bits and then 8 dummy bits, after which data streams as in R2.
- R4: With `long_pages` = 1, address bits [18:9] give the page and bits [8:0] give the byte offset. The first byte read is array index page*264 + offset.
- R5: With `long_pages` = 0, address bits [17:8] give the page and bits [7:0] give the byte. The first byte read is array index page*256 + byte.
- R6: After the last byte of a page, the next byte is byte 0 of the following page, with no extra SCK cycles.
- R7: After the last byte of the last page, the next byte is index 0, with no gap.
- R8: When chip select rises at any point, `spi_sdo_oe` is 0 within four clk cycles.
- R9: If chip select rises part way through a command, that command is abandoned, and the next command after chip select falls is decoded from its first bit.
- R10: Any opcode other than 8'hE8 or 8'h0B keeps `spi_sdo_oe` at 0 until chip select rises, however many SCK cycles follow.
- R11: Address bits above the page field are ignored, and the page number is taken modulo NUM_PAGES.
- R12: With `long_pages` = 1, an offset of 264 or more carries into the following page at offset-264. Past the last page, it continues from index 0.
- R13: Hosts that idle SCK low and hosts that idle SCK high receive the same data.
- R14: While `pl_we` = 1, the byte on `pl_data` is written at linear index `pl_addr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| long_pages | input | 1 | 1: 264-byte pages, 0: 256-byte pages |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Output enable for SDO, 0 means high impedance |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | IDX_W (12) | Preload linear byte index |
| pl_data | input | 8 | Preload byte |

## Verification
The bench starts reads just before a page end and near the top of the array, in both page geometries. A design that jumps or pauses at those points returns a shifted or stale byte there. It sends offsets of 264 and above, and addresses with high bits set. A design that fails to fold these back reads the wrong region, or an index beyond the array. Each opcode is run with its own don't-care length, so a wrong dummy count shows up as data shifted by whole bits. It also drops chip select mid-command and mid-data, sends an unknown opcode, and uses a host that idles the clock high. Each of these exposes a design that keeps stale decode state, drives the pin when it should not, or acts on the extra clock edge at chip select.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_REJECT
    } seq_state_e;

    localparam logic [7:0]  OPC_LEGACY        = 8'hE8;
    localparam logic [7:0]  OPC_FAST          = 8'h0B;
    localparam int unsigned LEGACY_DUMMY_BITS = 32;
    localparam int unsigned FAST_DUMMY_BITS   = 8;
    localparam int unsigned LONG_PAGE_BYTES   = 264;
    localparam int unsigned SHORT_PAGE_BYTES  = 256;
    localparam int unsigned ADDR_BITS         = 24;

    typedef struct packed {
        logic cs_n;
        logic sck_rise;
        logic sck_fall;
        logic sdi;
    } spi_evt_t;

    function automatic int unsigned array_bytes(logic long_pages, int unsigned num_pages);
        return long_pages ? num_pages * LONG_PAGE_BYTES : num_pages * SHORT_PAGE_BYTES;
    endfunction

    // Linear index of the first byte of a read, folded into the array.
    function automatic int unsigned start_index(logic long_pages,
                                                logic [ADDR_BITS-1:0] addr,
                                                int unsigned num_pages);
        int unsigned page;
        int unsigned offset;
        int unsigned idx;
        int unsigned depth;
        depth = array_bytes(long_pages, num_pages);
        if (long_pages) begin
            page   = {22'd0, addr[18:9]};
            offset = {23'd0, addr[8:0]};
        end else begin
            page   = {22'd0, addr[17:8]};
            offset = {24'd0, addr[7:0]};
        end
        page = page % num_pages;
        idx  = page * (long_pages ? LONG_PAGE_BYTES : SHORT_PAGE_BYTES) + offset;
        if (idx >= depth) begin
            idx = idx - depth;
        end
        return idx;
    endfunction

endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync
    import cr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     sdi,
    output spi_evt_t evt
);

    localparam int unsigned TAP = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   sck_pipe;
    logic [SYNC_STAGES-1:0] cs_pipe;
    logic [SYNC_STAGES-1:0] sdi_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_pipe <= '0;
            cs_pipe  <= '1;
            sdi_pipe <= '0;
        end else begin
            sck_pipe <= {sck_pipe[SYNC_STAGES-1:0], sck};
            cs_pipe  <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
            sdi_pipe <= {sdi_pipe[SYNC_STAGES-2:0], sdi};
        end
    end

    always_comb begin
        evt.cs_n     = cs_pipe[TAP];
        evt.sdi      = sdi_pipe[TAP];
        evt.sck_rise = sck_pipe[TAP] & ~sck_pipe[TAP+1];
        evt.sck_fall = ~sck_pipe[TAP] & sck_pipe[TAP+1];
    end

endmodule

// File: rtl/cr_cmd_seq.sv
module cr_cmd_seq
    import cr_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 8,
    parameter int unsigned IDX_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  spi_evt_t         evt,
    input  logic             long_pages,
    output seq_state_e       state,
    output logic [IDX_W-1:0] start_idx
);

    logic [5:0]           bit_cnt;
    logic [5:0]           dummy_last;
    logic [ADDR_BITS-1:0] shreg;
    logic [ADDR_BITS-1:0] shreg_next;

    assign shreg_next = {shreg[ADDR_BITS-2:0], evt.sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OPCODE;
            bit_cnt    <= '0;
            dummy_last <= '0;
            shreg      <= '0;
            start_idx  <= '0;
        end else if (evt.cs_n) begin
            state   <= ST_OPCODE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (evt.sck_rise) begin
            case (state)
                ST_OPCODE: begin
                    shreg <= shreg_next;
                    if (bit_cnt == 6'd7) begin
                        bit_cnt <= '0;
                        if (shreg_next[7:0] == OPC_LEGACY) begin
                            dummy_last <= 6'(LEGACY_DUMMY_BITS - 1);
                            state      <= ST_ADDR;
                        end else if (shreg_next[7:0] == OPC_FAST) begin
                            dummy_last <= 6'(FAST_DUMMY_BITS - 1);
                            state      <= ST_ADDR;
                        end else begin
                            state <= ST_REJECT;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 6'd1;
                    end
                end
                ST_ADDR: begin
                    shreg <= shreg_next;
                    if (bit_cnt == 6'(ADDR_BITS - 1)) begin
                        bit_cnt   <= '0;
                        start_idx <= IDX_W'(start_index(long_pages, shreg_next, NUM_PAGES));
                        state     <= ST_DUMMY;
                    end else begin
                        bit_cnt <= bit_cnt + 6'd1;
                    end
                end
                ST_DUMMY: begin
                    if (bit_cnt == dummy_last) begin
                        state <= ST_DATA;
                    end else begin
                        bit_cnt <= bit_cnt + 6'd1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/cr_streamer.sv
module cr_streamer
    import cr_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 8,
    parameter int unsigned IDX_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  spi_evt_t         evt,
    input  logic             long_pages,
    input  seq_state_e       state,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sdo,
    output logic             sdo_oe
);

    localparam int unsigned LONG_DEPTH  = NUM_PAGES * LONG_PAGE_BYTES;
    localparam int unsigned SHORT_DEPTH = NUM_PAGES * SHORT_PAGE_BYTES;

    logic [IDX_W-1:0] last_idx;
    logic [2:0]       bit_pos;

    assign last_idx = long_pages ? IDX_W'(LONG_DEPTH - 1) : IDX_W'(SHORT_DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
            bit_pos <= 3'd7;
            rd_idx  <= '0;
        end else if (evt.cs_n || state != ST_DATA) begin
            if (evt.cs_n) begin
                sdo    <= 1'b0;
                sdo_oe <= 1'b0;
            end
            bit_pos <= 3'd7;
            rd_idx  <= start_idx;
        end else if (evt.sck_fall) begin
            sdo     <= rd_data[bit_pos];
            sdo_oe  <= 1'b1;
            bit_pos <= bit_pos - 3'd1;
            if (bit_pos == 3'd0) begin
                rd_idx <= (rd_idx == last_idx) ? '0 : rd_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cr_array.sv
module cr_array #(
    parameter int unsigned DEPTH = 2112,
    parameter int unsigned IDX_W = 12
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && ({1'b0, wr_idx} < (IDX_W+1)'(DEPTH))) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cr_responder.sv
module cr_responder
    import cr_pkg::*;
#(
    parameter int unsigned NUM_PAGES   = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned DEPTH      = NUM_PAGES * LONG_PAGE_BYTES,
    localparam int unsigned IDX_W      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             long_pages,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             spi_sdi,
    output logic             spi_sdo,
    output logic             spi_sdo_oe,
    input  logic             pl_we,
    input  logic [IDX_W-1:0] pl_addr,
    input  logic [7:0]       pl_data
);

    spi_evt_t         evt;
    seq_state_e       seq_state;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;

    cr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .cs_n (spi_cs_n),
        .sdi  (spi_sdi),
        .evt  (evt)
    );

    cr_cmd_seq #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .long_pages (long_pages),
        .state      (seq_state),
        .start_idx  (start_idx)
    );

    cr_streamer #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) strm_i (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .long_pages (long_pages),
        .state      (seq_state),
        .start_idx  (start_idx),
        .rd_data    (rd_data),
        .rd_idx     (rd_idx),
        .sdo        (spi_sdo),
        .sdo_oe     (spi_sdo_oe)
    );

    cr_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) mem_i (
        .clk     (clk),
        .wr_en   (pl_we),
        .wr_idx  (pl_addr),
        .wr_data (pl_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cr_checks.sv
module cr_checks
    import cr_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 8,
    parameter int unsigned IDX_W     = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n_s,
    input logic             sck_fall,
    input logic             long_pages,
    input seq_state_e       state,
    input logic [IDX_W-1:0] rd_idx,
    input logic             sdo,
    input logic             sdo_oe
);

    localparam int unsigned LONG_LAST  = NUM_PAGES * LONG_PAGE_BYTES - 1;
    localparam int unsigned SHORT_LAST = NUM_PAGES * SHORT_PAGE_BYTES - 1;

    // R8: output released once synchronized chip select is high
    p_release_on_cs_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !sdo_oe);

    // R10: an unknown opcode never enables the output
    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJECT) |-> !sdo_oe);

    // R2: the pin is driven only in the data phase
    p_drive_only_data_r2: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (state == ST_DATA));

    // R2: data bit moves only after a falling SCK
    p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !cs_n_s && !sck_fall) |=> $stable(sdo));

    // R7: the read index never leaves the array of the active geometry
    p_index_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |->
            (32'(rd_idx) <= (long_pages ? LONG_LAST : SHORT_LAST)));

endmodule

bind cr_responder cr_checks #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n_s     (evt.cs_n),
    .sck_fall   (evt.sck_fall),
    .long_pages (long_pages),
    .state      (seq_state),
    .rd_idx     (rd_idx),
    .sdo        (spi_sdo),
    .sdo_oe     (spi_sdo_oe)
);

// File: tb/cr_responder_tb_top.sv
`timescale 1ns/1ps
module cr_responder_tb_top;

    localparam int NPG    = 8;
    localparam int DEP_L  = NPG * 264;
    localparam int DEP_S  = NPG * 256;
    localparam int IW     = 12;
    localparam int HALF   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          long_pages = 1'b1;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic          sdi = 1'b0;
    logic          sdo;
    logic          sdo_oe;
    logic          pl_we = 1'b0;
    logic [IW-1:0] pl_addr = '0;
    logic [7:0]    pl_data = '0;

    logic [7:0] model [DEP_L];
    logic [7:0] rx [16];
    bit         rx_oe_ok;
    bit         rx_oe_any;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #4 clk = ~clk;

    cr_responder #(.NUM_PAGES(NPG)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .long_pages (long_pages),
        .spi_sck    (sck),
        .spi_cs_n   (cs_n),
        .spi_sdi    (sdi),
        .spi_sdo    (sdo),
        .spi_sdo_oe (sdo_oe),
        .pl_we      (pl_we),
        .pl_addr    (pl_addr),
        .pl_data    (pl_data)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37) ^ (i >> 3) ^ 8'h5C);
    endfunction

    function automatic int exp_start(bit lp, logic [23:0] a);
        int pg;
        int off;
        int idx;
        if (lp) begin
            pg  = (int'(a) >> 9) & 1023;
            off = int'(a) & 511;
            idx = (pg % NPG) * 264 + off;
            if (idx >= DEP_L) idx -= DEP_L;
        end else begin
            pg  = (int'(a) >> 8) & 1023;
            off = int'(a) & 255;
            idx = (pg % NPG) * 256 + off;
        end
        return idx;
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic slot(input logic din, output logic dout, output logic doe);
        sdi = din;
        wait_clk(HALF);
        dout = sdo;
        doe  = sdo_oe;
        sck  = 1'b1;
        wait_clk(HALF);
        sck  = 1'b0;
    endtask

    task automatic cs_begin(bit mode3);
        sck = mode3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
        if (mode3) sck = 1'b0;
    endtask

    task automatic cs_end(bit mode3);
        if (mode3) begin
            wait_clk(HALF);
            sck = 1'b1;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        logic d;
        logic e;
        for (int i = n - 1; i >= 0; i--) begin
            slot(v[i], d, e);
            if (e) rx_oe_any = 1'b1;
        end
    endtask

    task automatic run_read(logic [7:0] opc, logic [23:0] a, bit mode3, int nbytes);
        logic d;
        logic e;
        int dummy;
        dummy = (opc == 8'hE8) ? 32 : 8;
        rx_oe_ok = 1'b1;
        cs_begin(mode3);
        send_bits({24'd0, opc}, 8);
        send_bits({8'd0, a}, 24);
        send_bits(32'hA5C3_F00F, dummy);
        for (int b = 0; b < nbytes; b++) begin
            for (int k = 7; k >= 0; k--) begin
                slot(1'b1, d, e);
                rx[b][k] = d;
                if (!e) rx_oe_ok = 1'b0;
            end
        end
        cs_end(mode3);
    endtask

    task automatic check_read(string req, bit lp, logic [7:0] opc, logic [23:0] a,
                              bit mode3, int nbytes);
        int st;
        int dep;
        int bad;
        int idx;
        long_pages = lp;
        wait_clk(2);
        run_read(opc, a, mode3, nbytes);
        st  = exp_start(lp, a);
        dep = lp ? DEP_L : DEP_S;
        bad = -1;
        for (int b = 0; b < nbytes; b++) begin
            idx = (st + b) % dep;
            if (bad < 0 && rx[b] !== model[idx]) bad = b;
        end
        if (bad >= 0) begin
            idx = (st + bad) % dep;
            check(1'b0, req, $sformatf("byte %0d at index %0d", bad, idx),
                  int'(rx[bad]), int'(model[idx]));
        end else begin
            check(1'b1, req, "data", 0, 0);
        end
        check(rx_oe_ok, req, "output enable during data", int'(rx_oe_ok), 1);
        check(sdo_oe == 1'b0, "R1", "output enable after chip select high", int'(sdo_oe), 0);
    endtask

    task automatic t_reset_r1();
        check(sdo_oe == 1'b0, "R1", "output enable after reset", int'(sdo_oe), 0);
    endtask

    task automatic t_legacy_r2_r4();
        check_read("R2/R4", 1'b1, 8'hE8, (24'd5 << 9) | 24'd17, 1'b0, 8);
    endtask

    task automatic t_fast_r3_r5();
        check_read("R3/R5", 1'b0, 8'h0B, (24'd6 << 8) | 24'd200, 1'b0, 8);
        check_read("R3", 1'b1, 8'h0B, (24'd1 << 9) | 24'd3, 1'b0, 4);
    endtask

    task automatic t_mode3_r13();
        check_read("R13", 1'b1, 8'h0B, (24'd2 << 9) | 24'd100, 1'b1, 4);
        check_read("R13", 1'b0, 8'hE8, (24'd3 << 8) | 24'd9, 1'b1, 4);
    endtask

    task automatic t_page_cross_r6();
        check_read("R6", 1'b1, 8'h0B, (24'd3 << 9) | 24'd261, 1'b0, 6);
        check_read("R6", 1'b0, 8'hE8, (24'd4 << 8) | 24'd254, 1'b0, 5);
    endtask

    task automatic t_wrap_r7();
        check_read("R7", 1'b1, 8'h0B, (24'd7 << 9) | 24'd262, 1'b0, 5);
        check_read("R7", 1'b0, 8'h0B, (24'd7 << 8) | 24'd253, 1'b0, 5);
    endtask

    task automatic t_high_bits_r11();
        check_read("R11", 1'b1, 8'hE8, 24'hF80000 | (24'd13 << 9) | 24'd40, 1'b0, 3);
        check_read("R11", 1'b0, 8'h0B, 24'hFC0000 | (24'd9 << 8) | 24'd7, 1'b0, 3);
    endtask

    task automatic t_offset_clamp_r12();
        check_read("R12", 1'b1, 8'h0B, (24'd3 << 9) | 24'd300, 1'b0, 3);
        check_read("R12", 1'b1, 8'hE8, (24'd7 << 9) | 24'd511, 1'b0, 3);
    endtask

    task automatic t_bad_opcode_r10();
        long_pages = 1'b1;
        rx_oe_any  = 1'b0;
        cs_begin(1'b0);
        send_bits(32'h03, 8);
        send_bits(32'h0001_0203, 32);
        send_bits(32'hFFFF_FFFF, 32);
        send_bits(32'h5555_AAAA, 32);
        cs_end(1'b0);
        check(rx_oe_any == 1'b0, "R10", "output enable after unknown opcode",
              int'(rx_oe_any), 0);
    endtask

    task automatic t_cs_abort_r8();
        logic d;
        logic e;
        long_pages = 1'b1;
        cs_begin(1'b0);
        send_bits(32'hE8, 8);
        send_bits((32'd1 << 9), 24);
        send_bits(32'h0, 32);
        for (int k = 0; k < 12; k++) slot(1'b0, d, e);
        check(e == 1'b1, "R8", "output enabled before abort", int'(e), 1);
        cs_n = 1'b1;
        wait_clk(4);
        check(sdo_oe == 1'b0, "R8", "output enable 4 cycles after chip select rise",
              int'(sdo_oe), 0);
        wait_clk(8);
    endtask

    task automatic t_cs_restart_r9();
        long_pages = 1'b1;
        cs_begin(1'b0);
        send_bits(32'hE8, 8);
        send_bits(32'h3FF, 10);
        cs_n = 1'b1;
        wait_clk(10);
        check_read("R9", 1'b1, 8'h0B, (24'd2 << 9) | 24'd5, 1'b0, 3);
        cs_begin(1'b0);
        send_bits(32'h0B, 8);
        send_bits(32'hFFFFFF, 24);
        send_bits(32'h1, 3);
        cs_n = 1'b1;
        wait_clk(10);
        check_read("R9", 1'b1, 8'hE8, (24'd6 << 9) | 24'd33, 1'b0, 3);
    endtask

    task automatic t_preload_r14();
        @(negedge clk);
        pl_we   = 1'b1;
        pl_addr = IW'(1500);
        pl_data = 8'h5A;
        model[1500] = 8'h5A;
        @(negedge clk);
        pl_we   = 1'b0;
        check_read("R14", 1'b1, 8'h0B, (24'd5 << 9) | 24'd180, 1'b0, 2);
        check(rx[0] == 8'h5A, "R14", "preloaded byte", int'(rx[0]), 'h5A);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        t_reset_r1();
        for (int i = 0; i < DEP_L; i++) begin
            pl_we   = 1'b1;
            pl_addr = IW'(i);
            pl_data = pat(i);
            model[i] = pat(i);
            @(negedge clk);
        end
        pl_we = 1'b0;
        wait_clk(2);
        t_legacy_r2_r4();
        t_fast_r3_r5();
        t_mode3_r13();
        t_page_cross_r6();
        t_wrap_r7();
        t_high_bits_r11();
        t_offset_clamp_r12();
        t_bad_opcode_r10();
        t_cs_abort_r8();
        t_cs_restart_r9();
        t_preload_r14();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule